// File: doc/BRIEF.md
# Inactivity Watchdog with Two-Stage Escalation

This block watches a system for signs of life. A down-counter is loaded from a programmable limit and runs while the block is enabled. A one-cycle pulse on the activity input reloads it. If the count runs out, the block raises an interrupt and loads the counter again for a second window. If that second window also runs out with no activity, a system reset output is driven for a fixed number of cycles. The block then returns to its first window and counts again.

Software reaches the block through a small synchronous register port. A control register holds the enable bit and an interrupt acknowledge bit. A limit register sets the window length. A read-only status register shows the live count and the pending interrupt flag. Read data is combinational from the address. Writes take effect at the clock edge that samples the write strobe.

Top module: `inact_watchdog`

## Requirements
- R1: After synchronous reset the block is disabled. Control reads 0, the limit reads DEF_LIMIT, status reads count DEF_LIMIT with pending 0, and both outputs are low.
- R2: The register map is as follows, with read data valid in the same cycle as the address. Address 0 is control: bit 0 is enable (read/write), and bit 1 is acknowledge (write-one-to-clear, reads 0). Address 1 is the limit in bits [CNT_W-1:0]. Address 2 is status: count in bits [CNT_W-1:0] and pending in bit CNT_W.
- R3: A restart loads the count with the limit L. The count drops by one per enabled cycle. The first expiry, L+1 cycles after the restart edge, sets pending, and the interrupt output rises at that edge.
- R4: If the second window expires with no activity, the reset output is high for exactly HOLD_CYC cycles. At release, pending clears, the count reloads L and the first window begins again.
- R5: An activity pulse while enabled, outside the reset phase, reloads the count and returns to the first window without clearing pending. If activity falls in the same cycle as an expiry, activity wins.
- R6: Writing 1 to the acknowledge bit clears pending. If the acknowledge falls in the cycle where a first expiry sets pending, pending stays set.
- R7: While disabled, the count, window stage and reset-phase timer hold still, and both outputs are low. Pending is kept and shows again once the block is enabled.
- R8: A limit write reloads the count with the written value at that same edge, even while disabled, so a shortened limit cannot expire at once.
- R9: Activity during the reset phase does not shorten or extend it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data, combinational |
| activity_i | input | 1 | Sign-of-life pulse |
| irq_o | output | 1 | Interrupt, pending flag gated by enable |
| wdog_rst_o | output | 1 | System reset request |

## Verification
Two pairs of functions can land on one edge. In the first pair, an acknowledge write arrives in the cycle where the first window expires. The bench times the write so both reach the same edge and expects the interrupt to stay high there and on the next cycle. In the second pair, an activity pulse arrives on the edge where the count sits at zero. The bench expects no interrupt at that edge, and the next interrupt exactly one full window after the pulse. Every expected output value is queued with its absolute cycle number before the stimulus is driven.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] REG_LIMIT = 2'd1;
    localparam logic [ADDR_W-1:0] REG_STAT  = 2'd2;

    localparam int CTRL_EN_POS  = 0;
    localparam int CTRL_ACK_POS = 1;

    typedef enum logic [1:0] {
        PH_WATCH = 2'd0,
        PH_WARN  = 2'd1,
        PH_BITE  = 2'd2
    } wdg_phase_e;

    typedef struct packed {
        logic enable;
        logic ack;
        logic reload;
    } wdg_cmd_t;

    // counting windows accept restarts; the reset phase does not
    function automatic logic phase_armed(wdg_phase_e ph);
        return ph != PH_BITE;
    endfunction

endpackage

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
    import wdg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 32,
    parameter int DEF_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              pend_i,
    output wdg_cmd_t          cmd_o,
    output logic [CNT_W-1:0]  limit_o
);

    logic             en_q;
    logic [CNT_W-1:0] limit_q;
    logic             wr_ctrl;
    logic             wr_limit;
    logic             unused_wdata;

    assign wr_ctrl      = cfg_wr && (cfg_addr == REG_CTRL);
    assign wr_limit     = cfg_wr && (cfg_addr == REG_LIMIT);
    assign unused_wdata = &{1'b0, cfg_wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            limit_q <= CNT_W'(DEF_LIMIT);
        end else begin
            if (wr_ctrl)  en_q    <= cfg_wdata[CTRL_EN_POS];
            if (wr_limit) limit_q <= cfg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        cmd_o.enable = en_q;
        cmd_o.ack    = wr_ctrl && cfg_wdata[CTRL_ACK_POS];
        cmd_o.reload = wr_limit;
        // forward a limit being written so the reload uses it on this edge
        limit_o      = wr_limit ? cfg_wdata[CNT_W-1:0] : limit_q;
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_CTRL:  cfg_rdata[CTRL_EN_POS] = en_q;
            REG_LIMIT: cfg_rdata[CNT_W-1:0]   = limit_q;
            REG_STAT: begin
                cfg_rdata[CNT_W-1:0] = cnt_i;
                cfg_rdata[CNT_W]     = pend_i;
            end
            default:   cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
    import wdg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int HOLD_CYC  = 16,
    parameter int DEF_LIMIT = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  wdg_cmd_t         cmd_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             activity_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pend_o,
    output logic             bite_o
);

    localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC - 1);

    wdg_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic             pend_q;

    logic restart;
    logic expire;
    logic bite_end;

    always_comb begin
        restart  = phase_armed(phase_q) &&
                   (cmd_i.reload || (cmd_i.enable && activity_i));
        expire   = phase_armed(phase_q) && !restart && cmd_i.enable &&
                   (cnt_q == '0);
        bite_end = (phase_q == PH_BITE) && cmd_i.enable && (hold_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_WATCH;
            cnt_q   <= CNT_W'(DEF_LIMIT);
            hold_q  <= '0;
        end else if (phase_q == PH_BITE) begin
            if (bite_end) begin
                phase_q <= PH_WATCH;
                cnt_q   <= limit_i;
            end else if (cmd_i.enable) begin
                hold_q  <= hold_q - 1'b1;
            end
        end else if (restart) begin
            phase_q <= PH_WATCH;
            cnt_q   <= limit_i;
        end else if (expire) begin
            cnt_q <= limit_i;
            if (phase_q == PH_WATCH) begin
                phase_q <= PH_WARN;
            end else begin
                phase_q <= PH_BITE;
                hold_q  <= HOLD_LOAD;
            end
        end else if (cmd_i.enable) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // setting on a first expiry takes priority over an acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (expire && (phase_q == PH_WATCH)) begin
            pend_q <= 1'b1;
        end else if (bite_end || cmd_i.ack) begin
            pend_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign pend_o = pend_q;
    assign bite_o = (phase_q == PH_BITE);

endmodule

// File: rtl/inact_watchdog.sv
module inact_watchdog
    import wdg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 32,
    parameter int HOLD_CYC  = 16,
    parameter int DEF_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              activity_i,
    output logic              irq_o,
    output logic              wdog_rst_o
);

    wdg_cmd_t         cmd;
    logic [CNT_W-1:0] limit_w;
    logic [CNT_W-1:0] cnt_w;
    logic             pend_w;
    logic             bite_w;
    logic             en_w;
    logic             reload_w;

    wdg_cfg_regs #(
        .CNT_W     (CNT_W),
        .DATA_W    (DATA_W),
        .DEF_LIMIT (DEF_LIMIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cnt_i     (cnt_w),
        .pend_i    (pend_w),
        .cmd_o     (cmd),
        .limit_o   (limit_w)
    );

    wdg_countdown #(
        .CNT_W     (CNT_W),
        .HOLD_CYC  (HOLD_CYC),
        .DEF_LIMIT (DEF_LIMIT)
    ) u_count (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd),
        .limit_i    (limit_w),
        .activity_i (activity_i),
        .cnt_o      (cnt_w),
        .pend_o     (pend_w),
        .bite_o     (bite_w)
    );

    assign en_w       = cmd.enable;
    assign reload_w   = cmd.reload;
    assign irq_o      = pend_w && en_w;
    assign wdog_rst_o = bite_w && en_w;

endmodule

// File: rtl/inact_watchdog_chk.sv
module inact_watchdog_chk #(
    parameter int CNT_W    = 16,
    parameter int HOLD_CYC = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             reload,
    input logic [CNT_W-1:0] cnt,
    input logic             activity_i,
    input logic             irq_o,
    input logic             wdog_rst_o
);

    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst)             run_len <= 0;
        else if (wdog_rst_o) run_len <= run_len + 1;
        else if (en)         run_len <= 0;
    end

    // R7: disabled means both outputs are quiet
    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!irq_o && !wdog_rst_o));

    // R7: a disabled counter only moves on a limit write
    p_frozen_count_r7: assert property (@(posedge clk) disable iff (rst)
        (!en && !reload) |=> $stable(cnt));

    // R4: a reset phase ended by its own timer lasts exactly HOLD_CYC cycles
    p_hold_length_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(wdog_rst_o) && en) |-> (run_len == HOLD_CYC));

    // R4: the reset phase starts only when a window has run out
    p_bite_from_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(wdog_rst_o) && $past(en)) |-> ($past(cnt) == '0));

    // R5: activity in a counting window cannot lead straight into reset
    p_activity_blocks_bite_r5: assert property (@(posedge clk) disable iff (rst)
        (en && activity_i && !wdog_rst_o) |=> !$rose(wdog_rst_o));

endmodule

bind inact_watchdog inact_watchdog_chk #(
    .CNT_W    (CNT_W),
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en_w),
    .reload     (reload_w),
    .cnt        (cnt_w),
    .activity_i (activity_i),
    .irq_o      (irq_o),
    .wdog_rst_o (wdog_rst_o)
);

// File: tb/inact_watchdog_test.sv
module inact_watchdog_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int DEF_LIMIT  = 1000;
    localparam logic [31:0] PEND = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_addr = 2'd0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [DATA_W-1:0] cfg_rdata;
    logic              activity_i = 1'b0;
    logic              irq_o;
    logic              wdog_rst_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        int    at;
        logic  irq;
        logic  wr;
        string tag;
    } exp_t;

    exp_t sb[$];

    inact_watchdog #(.DEF_LIMIT(DEF_LIMIT)) uut (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .activity_i (activity_i),
        .irq_o      (irq_o),
        .wdog_rst_o (wdog_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic expect_at(input int at, input logic i, input logic r, input string tag);
        exp_t e;
        e.at = at; e.irq = i; e.wr = r; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: pops scoreboard items as their cycle comes up
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            if (sb[0].at < cyc)
                chk(1'b0, {sb[0].tag, " missed"}, 32'(sb[0].at), 32'(cyc));
            else
                chk((irq_o === sb[0].irq) && (wdog_rst_o === sb[0].wr), sb[0].tag,
                    {30'd0, irq_o, wdog_rst_o}, {30'd0, sb[0].irq, sb[0].wr});
            void'(sb.pop_front());
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic ack_and_act();
        cfg_wr = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'd3; activity_i = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; activity_i = 1'b0;
    endtask

    task automatic pulse_act();
        activity_i = 1'b1;
        @(negedge clk);
        activity_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        cfg_addr = a;
        #1;
        chk(cfg_rdata === exp, tag, cfg_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int m;
        int p;
        int r;
        step(3);
        rst = 1'b0;

        // R1: reset state
        chk(!irq_o && !wdog_rst_o, "R1 outputs", {30'd0, irq_o, wdog_rst_o}, 32'd0);
        rd(2'd0, 32'd0, "R1 ctrl");
        rd(2'd1, 32'(DEF_LIMIT), "R1 limit");
        rd(2'd2, 32'(DEF_LIMIT), "R1 status");

        // R8/R7: limit write reloads while disabled, then count holds
        wr(2'd1, 32'd5);
        step(6);
        rd(2'd2, 32'd5, "R8 reload while off / R7 held");
        chk(!irq_o && !wdog_rst_o, "R7 quiet", {30'd0, irq_o, wdog_rst_o}, 32'd0);
        wr(2'd0, 32'd1);

        // R3/R4/R9: full escalation with limit 5
        n = cyc;
        expect_at(n+6,  0, 0, "R3 before expiry");
        expect_at(n+7,  1, 0, "R3 first expiry");
        expect_at(n+12, 1, 0, "R4 before second expiry");
        expect_at(n+13, 1, 1, "R4 reset rises");
        expect_at(n+28, 1, 1, "R9 reset held despite activity");
        expect_at(n+29, 0, 0, "R4 reset released");
        expect_at(n+34, 0, 0, "R4 counting again");
        expect_at(n+35, 1, 0, "R4 new first expiry");
        wr(2'd1, 32'd5);
        step(2);
        rd(2'd2, 32'd3, "R3 countdown value");
        step(17);
        pulse_act();
        step(15);
        rd(2'd2, PEND | 32'd4, "R2 status pending bit");

        // R6/R5: acknowledge with activity, then collisions
        m = cyc;
        expect_at(m+1,  0, 0, "R6 ack clears");
        expect_at(m+5,  0, 0, "R5 activity averted reset");
        expect_at(m+6,  0, 0, "R5 window after activity");
        expect_at(m+7,  1, 0, "R5 expiry after activity");
        expect_at(m+9,  0, 0, "R6 ack in warn window");
        expect_at(m+16, 0, 0, "R6 before collision");
        expect_at(m+17, 1, 0, "R6 set beats ack");
        expect_at(m+18, 1, 0, "R6 stays set");
        expect_at(m+20, 0, 0, "R6 cleared");
        expect_at(m+26, 0, 0, "R5 activity beats expiry");
        expect_at(m+27, 0, 0, "R5 no late irq");
        expect_at(m+31, 0, 0, "R5 window from collision");
        expect_at(m+32, 1, 0, "R5 expiry after collision");
        ack_and_act();
        step(7);
        wr(2'd0, 32'd3);
        step(1);
        pulse_act();
        step(5);
        wr(2'd0, 32'd3);
        step(2);
        ack_and_act();
        step(5);
        pulse_act();
        step(6);

        // R7: disable masks outputs and freezes, enable resumes
        p = cyc;
        expect_at(p+1,  0, 0, "R7 masked");
        expect_at(p+9,  0, 0, "R7 still masked");
        expect_at(p+10, 1, 0, "R7 pending shows again");
        expect_at(p+14, 1, 0, "R7 resumed count");
        expect_at(p+15, 1, 1, "R7 escalation after resume");
        expect_at(p+30, 1, 1, "R4 hold end");
        expect_at(p+31, 0, 0, "R4 release");
        wr(2'd0, 32'd0);
        step(3);
        rd(2'd2, PEND | 32'd4, "R7 frozen status");
        step(5);
        rd(2'd2, PEND | 32'd4, "R7 still frozen");
        wr(2'd0, 32'd1);
        step(21);

        // R8: shortened limit restarts rather than firing
        wr(2'd1, 32'd200);
        step(100);
        r = cyc;
        expect_at(r+4, 0, 0, "R8 no instant expiry");
        expect_at(r+5, 1, 0, "R8 expiry on new limit");
        wr(2'd1, 32'd3);
        rd(2'd1, 32'd3, "R2 limit readback");
        rd(2'd0, 32'd1, "R2 ack bit reads zero");
        step(6);

        while (sb.size() > 0) step(1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule